// File: doc/BRIEF.md
# Immediate Command Port

This block lets a host send one codec command at a time without using the command ring. The host first clears the response-valid flag. It then writes a 32-bit command word and sets the busy flag, and the block starts the transfer. The block offers the word on a valid/ready command output until the link takes it. It then waits for one 32-bit reply on the response input. When the reply arrives, the block stores it, raises the valid flag and drops busy, all in the same cycle. The host polls the status register for that. The top four command bits name the target codec, and the block also presents them on a separate output. Timeouts are left to the host.

The register port is a single-cycle write strobe with an address and a combinational read mux. Address 0 is the command word, address 1 is the response word, address 2 is the status register, and address 3 reads zero. In the status register, bit 0 is busy and bit 1 is response-valid.

Top module: `imm_cmd_port`

## Requirements
- R1: After reset, the status register (address 2) reads 0, the response register (address 1) reads 0 and `cmdValid` is low.
- R2: Writing status bit 0 as 1 while idle sets busy and raises `cmdValid` in the next cycle. `cmdData` then equals the last command written to address 0, and `cmdCodec` equals its bits 31:28.
- R3: While `cmdValid` is high and `cmdReady` is low, `cmdValid` stays high and `cmdData` stays unchanged. The handshake completes on the first edge where both are high.
- R4: A `rspValid` pulse after the handshake stores `rspData` in the response register, sets status bit 1 and clears status bit 0 on the same edge.
- R5: Writing 1 to status bit 1 clears the valid flag. Writing 0 to it leaves the flag unchanged. A reply stored on the same edge wins over the clear.
- R6: Writing status bit 0 as 1 while busy is ignored. It starts no second transfer.
- R7: A write to address 0 while busy leaves the stored command word unchanged.
- R8: A `rspValid` pulse when no command is waiting for a reply is dropped. This covers idle and the case where the command has not yet been handed over. The response register and the valid flag are unchanged.
- R9: Busy reads 1 from the launch edge until the edge that stores the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 command, 1 response, 2 status) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| cmdValid | output | 1 | Command word offered to the link |
| cmdReady | input | 1 | Link accepts the command word |
| cmdData | output | 32 | Command word |
| cmdCodec | output | 4 | Target codec address (command bits 31:28) |
| rspValid | input | 1 | Reply word present this cycle |
| rspData | input | 32 | Reply word |

## Verification
The assertions assume that `rspValid` is a single-cycle pulse and that `cmdReady` changes only between edges. They make no assumption about when a reply may arrive, because stray replies are part of the defined behaviour. The directed tasks drive every input on the falling edge and hold reply pulses to one cycle. They deliberately inject replies while the block is idle and while the command is still stalled, to exercise the drop rule.

// File: rtl/imm_port_pkg.sv
package imm_port_pkg;
  localparam int DATA_W    = 32;
  localparam int REG_AW    = 2;
  localparam int CODEC_W   = 4;
  localparam int BUSY_BIT  = 0;
  localparam int VALID_BIT = 1;

  localparam logic [REG_AW-1:0] ADDR_CMD    = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_RSP    = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic loadCmd;
    logic loadRsp;
  } dpStrobe_t;
endpackage

// File: rtl/imm_ctrl.sv
module imm_ctrl
  import imm_port_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic          wrBusyBit,
  input  logic          wrValidBit,
  input  logic          cmdReady,
  input  logic          rspValid,
  output dpStrobe_t     strobe,
  output logic          busy,
  output logic          rspFlag,
  output logic          cmdValid
);
  ctrlState_t state, stateNext;
  logic launch, clearValid, accept;

  assign launch     = regWrEn && (regAddr == ADDR_STATUS) && wrBusyBit && (state == ST_IDLE);
  assign clearValid = regWrEn && (regAddr == ADDR_STATUS) && wrValidBit;
  assign accept     = (state == ST_WAIT) && rspValid;

  assign strobe.loadCmd = regWrEn && (regAddr == ADDR_CMD) && (state == ST_IDLE);
  assign strobe.loadRsp = accept;

  assign busy     = (state != ST_IDLE);
  assign cmdValid = (state == ST_SEND);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (launch) stateNext = ST_SEND;
      ST_SEND: if (cmdReady) stateNext = ST_WAIT;
      ST_WAIT: if (rspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rspFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept)          rspFlag <= 1'b1;
      else if (clearValid) rspFlag <= 1'b0;
    end
  end

  // R3: offered command stays up until taken
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid);
  // R4: reply stored -> valid set and busy cleared together
  p_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) && rspValid |=> !busy && rspFlag);
  // R5: clear-by-one works when no reply competes
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    clearValid && !accept |=> !rspFlag);
  // R6: second launch while busy does nothing to the transfer
  p_relaunch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) && !rspValid |=> busy && !cmdValid);
  // R8: stray reply leaves the flag alone
  p_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (state != ST_WAIT) && !clearValid |=> $stable(rspFlag));
endmodule

// File: rtl/imm_datapath.sv
module imm_datapath
  import imm_port_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = REG_AW,
  parameter int CW = CODEC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [DW-1:0] regWrData,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] rspData,
  input  logic          busy,
  input  logic          rspFlag,
  input  logic          cmdValid,
  output logic [DW-1:0] cmdData,
  output logic [CW-1:0] cmdCodec,
  output logic [DW-1:0] regRdData
);
  localparam int CODEC_LSB = DW - CW;

  logic [DW-1:0] cmdWord, rspWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWord <= '0;
      rspWord <= '0;
    end else begin
      if (strobe.loadCmd) cmdWord <= regWrData;
      if (strobe.loadRsp) rspWord <= rspData;
    end
  end

  assign cmdData  = cmdWord;
  assign cmdCodec = cmdWord[DW-1:CODEC_LSB];

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CMD:    regRdData = cmdWord;
      ADDR_RSP:    regRdData = rspWord;
      ADDR_STATUS: begin
        regRdData[BUSY_BIT]  = busy;
        regRdData[VALID_BIT] = rspFlag;
      end
      default:     regRdData = '0;
    endcase
  end

  // R7: command word frozen while busy
  p_cmd_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cmdWord));
  // R3: offered data stable across a stall
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> $stable(cmdData));
endmodule

// File: rtl/imm_cmd_port.sv
module imm_cmd_port
  import imm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                cmdValid,
  input  logic                cmdReady,
  output logic [DATA_W-1:0]   cmdData,
  output logic [CODEC_W-1:0]  cmdCodec,
  input  logic                rspValid,
  input  logic [DATA_W-1:0]   rspData
);
  dpStrobe_t strobe;
  logic busy, rspFlag;

  imm_ctrl #(.AW(REG_AW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .wrBusyBit  (regWrData[BUSY_BIT]),
    .wrValidBit (regWrData[VALID_BIT]),
    .cmdReady   (cmdReady),
    .rspValid   (rspValid),
    .strobe     (strobe),
    .busy       (busy),
    .rspFlag    (rspFlag),
    .cmdValid   (cmdValid)
  );

  imm_datapath #(.DW(DATA_W), .AW(REG_AW), .CW(CODEC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .regAddr   (regAddr),
    .rspData   (rspData),
    .busy      (busy),
    .rspFlag   (rspFlag),
    .cmdValid  (cmdValid),
    .cmdData   (cmdData),
    .cmdCodec  (cmdCodec),
    .regRdData (regRdData)
  );

  // R9: busy falls only on the edge that sets the valid flag
  p_busy_span_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $rose(rspFlag) || (rspFlag && $past(rspFlag) == 1'b0));
endmodule

// File: tb/tb_imm_cmd_port.sv
module tb_imm_cmd_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic cmdValid, cmdReady = 1'b1;
  logic [31:0] cmdData;
  logic [3:0] cmdCodec;
  logic rspValid = 1'b0;
  logic [31:0] rspData = '0;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  imm_cmd_port dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdData(cmdData), .cmdCodec(cmdCodec),
    .rspValid(rspValid), .rspData(rspData)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulseRsp(logic [31:0] d);
    @(negedge clk);
    rspValid = 1'b1; rspData = d;
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd2, v); check("R1 status", v, 32'h0);
    rd(2'd1, v); check("R1 response", v, 32'h0);
    check("R1 cmdValid", {31'd0, cmdValid}, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    cmdReady = 1'b1;
    wr(2'd0, 32'h3ABC_1234);
    wr(2'd2, 32'h2);
    wr(2'd2, 32'h1);
    check("R2 cmdValid", {31'd0, cmdValid}, 32'h1);
    check("R2 cmdData", cmdData, 32'h3ABC_1234);
    check("R2 cmdCodec", {28'd0, cmdCodec}, 32'h3);
    rd(2'd2, v); check("R9 busy during send", v, 32'h1);
    @(negedge clk);
    check("R2 handshake done", {31'd0, cmdValid}, 32'h0);
    rd(2'd2, v); check("R9 busy while waiting", v, 32'h1);
    pulseRsp(32'hCAFE_0001);
    rd(2'd2, v); check("R4 valid set busy clear", v, 32'h2);
    rd(2'd1, v); check("R4 response", v, 32'hCAFE_0001);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    wr(2'd2, 32'h2);
    wr(2'd0, 32'hB000_00AA);
    cmdReady = 1'b0;
    wr(2'd2, 32'h1);
    for (int i = 0; i < 3; i++) begin
      check("R3 held valid", {31'd0, cmdValid}, 32'h1);
      check("R3 held data", cmdData, 32'hB000_00AA);
      @(negedge clk);
    end
    check("R2 codec in stall", {28'd0, cmdCodec}, 32'hB);
    pulseRsp(32'h0BAD_0BAD);
    rd(2'd2, v); check("R8 reply before handover dropped", v, 32'h1);
    cmdReady = 1'b1;
    @(negedge clk);
    check("R3 taken", {31'd0, cmdValid}, 32'h0);
    pulseRsp(32'h1111_2222);
    rd(2'd1, v); check("R4 stall response", v, 32'h1111_2222);
    rd(2'd2, v); check("R4 stall status", v, 32'h2);
  endtask

  task automatic t_busy_writes();
    logic [31:0] v;
    wr(2'd2, 32'h2);
    wr(2'd0, 32'h5000_0055);
    wr(2'd2, 32'h1);
    @(negedge clk);
    wr(2'd2, 32'h1);
    check("R6 no relaunch", {31'd0, cmdValid}, 32'h0);
    wr(2'd0, 32'h7777_7777);
    rd(2'd0, v); check("R7 cmd unchanged", v, 32'h5000_0055);
    pulseRsp(32'h3333_4444);
    rd(2'd2, v); check("R6 single reply ends busy", v, 32'h2);
    check("R6 no extra transfer", {31'd0, cmdValid}, 32'h0);
    wr(2'd2, 32'h3);
    check("R7 relaunch sends old word", cmdData, 32'h5000_0055);
    rd(2'd2, v); check("R5 clear with launch", v, 32'h1);
    @(negedge clk);
    pulseRsp(32'h5555_6666);
  endtask

  task automatic t_stray();
    logic [31:0] v;
    pulseRsp(32'hDEAD_BEEF);
    rd(2'd1, v); check("R8 idle reply dropped", v, 32'h5555_6666);
    rd(2'd2, v); check("R8 status unchanged", v, 32'h2);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(2'd2, 32'h0);
    rd(2'd2, v); check("R5 write 0 keeps valid", v, 32'h2);
    wr(2'd2, 32'h2);
    rd(2'd2, v); check("R5 write 1 clears valid", v, 32'h0);
    rd(2'd3, v); check("R1 unmapped reads 0", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_stall();
    t_busy_writes();
    t_stray();
    t_clear();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule